// File: doc/BRIEF.md
# Two-Slot Alternating Byte DMA Channel

This block moves a byte stream between memory and a peripheral using two transfer slots, A and B, that software loads in turn. While the engine drains one slot, software refills the other and marks it valid. When the engine finishes a slot, it clears that slot's valid flag and turns to the other slot. If the other slot is not yet valid, the engine waits in idle. Each slot word gives a base address, a byte length and an end-of-stream flag. When that flag is set, a terminal-count pulse follows once the buffer is done.

Software reaches the block through a small register port with a one-cycle read latency. Memory traffic uses a single-byte request/grant port. The peripheral side uses valid/ready byte streams, one for each direction. A slot is refused if its buffer would run past the end of a 4 KiB page. In the device-to-memory direction, a slot is also refused if its base is not 64-byte aligned. A refused slot produces an error interrupt and no traffic. The channel can be frozen at any point and resumed later, or fully reset through the control word.

Top module: `pingpong_dma`

## Requirements
- R1: Register word 0 is slot A and word 1 is slot B. Word 2 is control/status and word 3 is the read-only diagnostic. In a slot word, bits 31:0 are the base, bits 43:32 are the length and bit 63 is the end flag. A write to slots A or B is read back unchanged. reg_rdata shows the addressed word one clock after reg_addr is presented.
- R2: With control bit 0 clear (memory to device), the engine reads bytes from base, base+1, … base+len-1 in that order. Each byte is offered on the outgoing stream, and the stream holds valid and data until ready.
- R3: With control bit 0 set (device to memory), each byte accepted on the incoming stream is written to base+i in arrival order. A pending memory request holds its address until it is granted.
- R4: After any reset the engine serves slot A first. When a slot finishes, its valid flag clears (control bit 4 for A, bit 3 for B) and the engine turns to the other slot. If that slot is not valid, the engine idles until software sets it.
- R5: Finishing slot A gives a one-cycle pulse on irq_a, and finishing slot B gives one on irq_b.
- R6: tc_pulse rises with the completion pulse only when the finished slot's end flag is set.
- R7: A slot is refused if the low 12 bits of its base plus its length exceed 4096. A refused slot gives one irq_err pulse, makes no memory or stream traffic, clears its valid flag and passes control to the other slot. A buffer that ends exactly on the page boundary runs normally.
- R8: In device-to-memory mode, a base with any of bits 5:0 set is refused as in R7. In memory-to-device mode, any byte alignment is accepted.
- R9: With control bit 1 (enable) clear, no request, stream valid or stream ready is driven, and counters, address and slot hold still. Setting the bit again resumes exactly where the engine stopped.
- R10: A control write with bit 2 set clears both valid flags, the byte counter and the active state, and returns the engine to slot A. Bit 2 always reads as 0.
- R11: Diagnostic bit 0 shows the slot in use (1 = B), bit 1 shows that a transfer is running, and bits 13:2 show the bytes still to move.
- R12: A length of 0 completes at once, with no memory or stream traffic, but still produces the completion interrupt and tc_pulse when the end flag is set.
- R13: Writing 0 to a valid flag bit has no effect. Only the engine clears valid flags, apart from the reset of R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word select |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Registered read data |
| mem_req | output | 1 | Memory byte request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rdata | input | 8 | Read byte, valid with mem_gnt |
| st_out_valid | output | 1 | Outgoing byte valid |
| st_out_data | output | 8 | Outgoing byte |
| st_out_ready | input | 1 | Peripheral accepts outgoing byte |
| st_in_valid | input | 1 | Incoming byte valid |
| st_in_data | input | 8 | Incoming byte |
| st_in_ready | output | 1 | Engine accepts incoming byte |
| tc_pulse | output | 1 | Terminal-count pulse |
| irq_a | output | 1 | Slot A finished |
| irq_b | output | 1 | Slot B finished |
| irq_err | output | 1 | Slot refused |

## Verification
A wrong pointer or counter shows up at once in the byte stream: the next outgoing byte or memory write lands at the wrong address or with the wrong value, or the burst has one byte too many or too few. A wrong slot index or valid flag shows up at the next completion as the wrong interrupt line, as a missing tc_pulse, or as a slot that runs twice or never. A freeze that leaks shows up as stream beats appearing during the hold window. A freeze that is resumed wrongly shows up as a changed diagnostic count or a duplicated byte.

// File: rtl/pp_dma_pkg.sv
package pp_dma_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_PUSH,
    ST_PULL,
    ST_STORE
  } eng_state_e;

  // slot word layout
  localparam int SLOT_W       = 64;
  localparam int SLOT_LEN_LSB = 32;
  localparam int SLOT_END_BIT = 63;

  // control/status bit positions
  localparam int CTL_DIR = 0;
  localparam int CTL_EN  = 1;
  localparam int CTL_RST = 2;
  localparam int CTL_VB  = 3;
  localparam int CTL_VA  = 4;

  // register word indices
  localparam logic [1:0] RW_SLOT_A = 2'd0;
  localparam logic [1:0] RW_SLOT_B = 2'd1;
  localparam logic [1:0] RW_CTL    = 2'd2;
  localparam logic [1:0] RW_DIAG   = 2'd3;

endpackage

// File: rtl/pp_dma_regs.sv
module pp_dma_regs
  import pp_dma_pkg::*;
#(
  parameter int LEN_W = 12,
  parameter int NSLOT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [SLOT_W-1:0] reg_wdata,
  output logic [SLOT_W-1:0] reg_rdata,
  input  logic [NSLOT-1:0]  clr_valid,
  input  logic              eng_cur,
  input  logic              eng_active,
  input  logic [LEN_W-1:0]  eng_cnt,
  output logic [SLOT_W-1:0] slot_a,
  output logic [SLOT_W-1:0] slot_b,
  output logic [NSLOT-1:0]  slot_valid,
  output logic              ctl_dir,
  output logic              ctl_en,
  output logic              ctl_wr,
  output logic              soft_rst
);

  logic [SLOT_W-1:0] slot_mem [NSLOT];
  logic [NSLOT-1:0]  set_valid;

  assign ctl_wr   = reg_wr && (reg_addr == RW_CTL);
  assign soft_rst = ctl_wr && reg_wdata[CTL_RST];
  // index 0 is slot A, index 1 is slot B
  assign set_valid = ctl_wr ? {reg_wdata[CTL_VB], reg_wdata[CTL_VA]} : '0;

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)
        slot_mem[g] <= '0;
      else if (reg_wr && (reg_addr == 2'(g)))
        slot_mem[g] <= reg_wdata;
    end
  end

  assign slot_a = slot_mem[0];
  assign slot_b = slot_mem[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_valid <= '0;
      ctl_dir    <= 1'b0;
      ctl_en     <= 1'b0;
    end else begin
      if (soft_rst)
        slot_valid <= '0;
      else
        slot_valid <= (slot_valid & ~clr_valid) | set_valid;
      if (ctl_wr) begin
        ctl_dir <= reg_wdata[CTL_DIR];
        ctl_en  <= reg_wdata[CTL_EN];
      end
    end
  end

  logic [SLOT_W-1:0] ctl_word, diag_word;

  always_comb begin
    ctl_word          = '0;
    ctl_word[CTL_DIR] = ctl_dir;
    ctl_word[CTL_EN]  = ctl_en;
    ctl_word[CTL_VA]  = slot_valid[0];
    ctl_word[CTL_VB]  = slot_valid[1];
    diag_word         = SLOT_W'({eng_cnt, eng_active, eng_cur});
  end

  always_ff @(posedge clk) begin
    if (rst)
      reg_rdata <= '0;
    else begin
      unique case (reg_addr)
        RW_SLOT_A: reg_rdata <= slot_mem[0];
        RW_SLOT_B: reg_rdata <= slot_mem[1];
        RW_CTL:    reg_rdata <= ctl_word;
        default:   reg_rdata <= diag_word;
      endcase
    end
  end

endmodule

// File: rtl/pp_dma_engine.sv
module pp_dma_engine
  import pp_dma_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int LEN_W   = 12,
  parameter int PAGE_W  = 12,
  parameter int ALIGN_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic              run_en,
  input  logic              dir,
  input  logic [SLOT_W-1:0] slot_a,
  input  logic [SLOT_W-1:0] slot_b,
  input  logic [1:0]        slot_valid,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic              mem_gnt,
  input  logic [7:0]        mem_rdata,
  output logic              st_out_valid,
  output logic [7:0]        st_out_data,
  input  logic              st_out_ready,
  input  logic              st_in_valid,
  input  logic [7:0]        st_in_data,
  output logic              st_in_ready,
  output logic [1:0]        clr_valid,
  output logic              fin_ok,
  output logic              fin_err,
  output logic              fin_slot,
  output logic              fin_last,
  output logic              cur,
  output logic              active,
  output logic [LEN_W-1:0]  cnt
);

  localparam int SUM_W = PAGE_W + 1;
  localparam logic [SUM_W-1:0] PAGE_BYTES = {1'b1, {PAGE_W{1'b0}}};

  eng_state_e        state;
  logic [ADDR_W-1:0] ptr;
  logic              last_q;
  logic [7:0]        hold;

  logic [SLOT_W-1:0] sel;
  logic [ADDR_W-1:0] sel_base;
  logic [LEN_W-1:0]  sel_len;
  logic              sel_end;
  logic [SUM_W-1:0]  span;
  logic              crosses, misalign, bad, start, byte_done, final_beat;

  assign sel      = cur ? slot_b : slot_a;
  assign sel_base = sel[ADDR_W-1:0];
  assign sel_len  = sel[SLOT_LEN_LSB +: LEN_W];
  assign sel_end  = sel[SLOT_END_BIT];
  assign span     = SUM_W'(sel_base[PAGE_W-1:0]) + SUM_W'(sel_len);
  assign crosses  = span > PAGE_BYTES;
  assign misalign = dir && (|sel_base[ALIGN_W-1:0]);
  assign bad      = crosses || misalign;

  assign start      = run_en && !soft_rst && (state == ST_IDLE) && slot_valid[cur];
  assign byte_done  = run_en && !soft_rst &&
                      (((state == ST_PUSH) && st_out_ready) ||
                       ((state == ST_STORE) && mem_gnt));
  assign final_beat = byte_done && (cnt == LEN_W'(1));

  assign fin_ok    = (start && !bad && (sel_len == '0)) || final_beat;
  assign fin_err   = start && bad;
  assign fin_slot  = cur;
  assign fin_last  = start ? sel_end : last_q;
  assign clr_valid = (fin_ok || fin_err) ? (cur ? 2'b10 : 2'b01) : 2'b00;

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      state  <= ST_IDLE;
      cur    <= 1'b0;
      ptr    <= '0;
      cnt    <= '0;
      last_q <= 1'b0;
      hold   <= '0;
    end else if (run_en) begin
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            if (bad || (sel_len == '0)) begin
              cur <= ~cur;
            end else begin
              ptr    <= sel_base;
              cnt    <= sel_len;
              last_q <= sel_end;
              state  <= dir ? ST_PULL : ST_FETCH;
            end
          end
        end
        ST_FETCH: begin
          if (mem_gnt) begin
            hold  <= mem_rdata;
            state <= ST_PUSH;
          end
        end
        ST_PUSH: begin
          if (st_out_ready) begin
            ptr <= ptr + ADDR_W'(1);
            cnt <= cnt - LEN_W'(1);
            if (cnt == LEN_W'(1)) begin
              state <= ST_IDLE;
              cur   <= ~cur;
            end else begin
              state <= ST_FETCH;
            end
          end
        end
        ST_PULL: begin
          if (st_in_valid) begin
            hold  <= st_in_data;
            state <= ST_STORE;
          end
        end
        ST_STORE: begin
          if (mem_gnt) begin
            ptr <= ptr + ADDR_W'(1);
            cnt <= cnt - LEN_W'(1);
            if (cnt == LEN_W'(1)) begin
              state <= ST_IDLE;
              cur   <= ~cur;
            end else begin
              state <= ST_PULL;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign mem_req      = run_en && ((state == ST_FETCH) || (state == ST_STORE));
  assign mem_we       = (state == ST_STORE);
  assign mem_addr     = ptr;
  assign mem_wdata    = hold;
  assign st_out_valid = run_en && (state == ST_PUSH);
  assign st_out_data  = hold;
  assign st_in_ready  = run_en && (state == ST_PULL);
  assign active       = (state != ST_IDLE);

endmodule

// File: rtl/pp_dma_irq.sv
module pp_dma_irq (
  input  logic clk,
  input  logic rst,
  input  logic fin_ok,
  input  logic fin_err,
  input  logic fin_slot,
  input  logic fin_last,
  output logic irq_a,
  output logic irq_b,
  output logic irq_err,
  output logic tc_pulse
);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_a    <= 1'b0;
      irq_b    <= 1'b0;
      irq_err  <= 1'b0;
      tc_pulse <= 1'b0;
    end else begin
      irq_a    <= fin_ok && !fin_slot;
      irq_b    <= fin_ok && fin_slot;
      irq_err  <= fin_err;
      tc_pulse <= fin_ok && fin_last;
    end
  end

endmodule

// File: rtl/pingpong_dma.sv
module pingpong_dma
  import pp_dma_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int LEN_W   = 12,
  parameter int PAGE_W  = 12,
  parameter int ALIGN_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [63:0]       reg_wdata,
  output logic [63:0]       reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic              mem_gnt,
  input  logic [7:0]        mem_rdata,
  output logic              st_out_valid,
  output logic [7:0]        st_out_data,
  input  logic              st_out_ready,
  input  logic              st_in_valid,
  input  logic [7:0]        st_in_data,
  output logic              st_in_ready,
  output logic              tc_pulse,
  output logic              irq_a,
  output logic              irq_b,
  output logic              irq_err
);

  logic [SLOT_W-1:0] slot_a, slot_b;
  logic [1:0]        slot_valid, clr_valid;
  logic              run_en, ctl_dir, ctl_wr, soft_rst;
  logic              eng_cur, eng_active;
  logic [LEN_W-1:0]  eng_cnt;
  logic              fin_ok, fin_err, fin_slot, fin_last;

  pp_dma_regs #(.LEN_W(LEN_W), .NSLOT(2)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .clr_valid  (clr_valid),
    .eng_cur    (eng_cur),
    .eng_active (eng_active),
    .eng_cnt    (eng_cnt),
    .slot_a     (slot_a),
    .slot_b     (slot_b),
    .slot_valid (slot_valid),
    .ctl_dir    (ctl_dir),
    .ctl_en     (run_en),
    .ctl_wr     (ctl_wr),
    .soft_rst   (soft_rst)
  );

  pp_dma_engine #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_W(PAGE_W), .ALIGN_W(ALIGN_W)
  ) u_eng (
    .clk          (clk),
    .rst          (rst),
    .soft_rst     (soft_rst),
    .run_en       (run_en),
    .dir          (ctl_dir),
    .slot_a       (slot_a),
    .slot_b       (slot_b),
    .slot_valid   (slot_valid),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .mem_gnt      (mem_gnt),
    .mem_rdata    (mem_rdata),
    .st_out_valid (st_out_valid),
    .st_out_data  (st_out_data),
    .st_out_ready (st_out_ready),
    .st_in_valid  (st_in_valid),
    .st_in_data   (st_in_data),
    .st_in_ready  (st_in_ready),
    .clr_valid    (clr_valid),
    .fin_ok       (fin_ok),
    .fin_err      (fin_err),
    .fin_slot     (fin_slot),
    .fin_last     (fin_last),
    .cur          (eng_cur),
    .active       (eng_active),
    .cnt          (eng_cnt)
  );

  pp_dma_irq u_irq (
    .clk      (clk),
    .rst      (rst),
    .fin_ok   (fin_ok),
    .fin_err  (fin_err),
    .fin_slot (fin_slot),
    .fin_last (fin_last),
    .irq_a    (irq_a),
    .irq_b    (irq_b),
    .irq_err  (irq_err),
    .tc_pulse (tc_pulse)
  );

endmodule

// File: rtl/pp_dma_checks.sv
module pp_dma_checks #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              run_en,
  input logic              ctl_wr,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_gnt,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              st_out_valid,
  input logic              st_out_ready,
  input logic [7:0]        st_out_data,
  input logic              st_in_ready,
  input logic              irq_a,
  input logic              irq_b,
  input logic              irq_err,
  input logic              tc_pulse
);

  // R2: an offered byte stays put until taken
  a_r2_out_hold: assert property (@(posedge clk) disable iff (rst)
    st_out_valid && !st_out_ready && !ctl_wr |=> st_out_valid && $stable(st_out_data));

  // R3: an ungranted memory request keeps its address and kind
  a_r3_req_hold: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_gnt && !ctl_wr |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  // R5: completion pulses last one cycle and never coincide
  a_r5_irq_a_pulse: assert property (@(posedge clk) disable iff (rst)
    irq_a |=> !irq_a);
  a_r5_irq_excl: assert property (@(posedge clk) disable iff (rst)
    !(irq_a && irq_b));

  // R6: terminal count only accompanies a completion
  a_r6_tc_with_done: assert property (@(posedge clk) disable iff (rst)
    tc_pulse |-> (irq_a || irq_b));

  // R7: a refused slot is never also reported as finished
  a_r7_err_alone: assert property (@(posedge clk) disable iff (rst)
    irq_err |-> !irq_a && !irq_b);

  // R9: a frozen channel drives no handshakes
  a_r9_frozen_quiet: assert property (@(posedge clk) disable iff (rst)
    !run_en |-> !mem_req && !st_out_valid && !st_in_ready);

endmodule

bind pingpong_dma pp_dma_checks #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .run_en       (run_en),
  .ctl_wr       (ctl_wr),
  .mem_req      (mem_req),
  .mem_we       (mem_we),
  .mem_gnt      (mem_gnt),
  .mem_addr     (mem_addr),
  .st_out_valid (st_out_valid),
  .st_out_ready (st_out_ready),
  .st_out_data  (st_out_data),
  .st_in_ready  (st_in_ready),
  .irq_a        (irq_a),
  .irq_b        (irq_b),
  .irq_err      (irq_err),
  .tc_pulse     (tc_pulse)
);

// File: tb/pingpong_dma_test.sv
module pingpong_dma_test;

  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] C_DIR = 64'h1, C_EN = 64'h2, C_RST = 64'h4,
                          C_VB = 64'h8, C_VA = 64'h10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic        mem_req, mem_we, mem_gnt;
  logic [31:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        st_out_valid, st_in_ready;
  logic [7:0]  st_out_data;
  logic        st_out_ready = 1'b0;
  logic        st_in_valid = 1'b0;
  logic [7:0]  st_in_data = '0;
  logic        tc_pulse, irq_a, irq_b, irq_err;
  logic        gnt_en = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  int vectors = 0, fails = 0;
  int n_a = 0, n_b = 0, n_e = 0, n_tc = 0, beats = 0, reads = 0, writes = 0;
  bit done_flag = 0;

  logic [7:0]  exp_out[$];
  logic [39:0] exp_wr[$];
  logic [7:0]  src_in[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] mem_pat(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  function automatic logic [63:0] slot_word(input logic [31:0] base,
                                            input logic [11:0] len, input logic last);
    return {last, 19'd0, len, base};
  endfunction

  assign mem_gnt   = mem_req && gnt_en;
  assign mem_rdata = mem_pat(mem_addr);

  pingpong_dma uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
    .st_out_valid(st_out_valid), .st_out_data(st_out_data),
    .st_out_ready(st_out_ready), .st_in_valid(st_in_valid),
    .st_in_data(st_in_data), .st_in_ready(st_in_ready),
    .tc_pulse(tc_pulse), .irq_a(irq_a), .irq_b(irq_b), .irq_err(irq_err)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: pick new bench inputs, then score the handshakes of the coming edge
  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (rst) begin
      st_out_ready = 1'b0; gnt_en = 1'b0; st_in_valid = 1'b0;
    end else begin
      st_out_ready = lfsr[0] | lfsr[3];
      gnt_en       = lfsr[1] | lfsr[5];
      st_in_valid  = (src_in.size() != 0) && (lfsr[2] | lfsr[7]);
      st_in_data   = (src_in.size() != 0) ? src_in[0] : 8'h00;
      if (st_out_valid && st_out_ready) begin
        beats++;
        if (exp_out.size() == 0) check("R2 unexpected stream beat", {56'd0, st_out_data}, 64'hDEAD);
        else check("R2 outgoing byte", {56'd0, st_out_data}, {56'd0, exp_out.pop_front()});
      end
      if (mem_req && gnt_en && mem_we) begin
        writes++;
        if (exp_wr.size() == 0) check("R3 unexpected write", {24'd0, mem_addr, mem_wdata}, 64'hDEAD);
        else check("R3 memory write", {24'd0, mem_addr, mem_wdata}, {24'd0, exp_wr.pop_front()});
      end
      if (mem_req && gnt_en && !mem_we) reads++;
      if (st_in_valid && st_in_ready) void'(src_in.pop_front());
      if (irq_a) n_a++;
      if (irq_b) n_b++;
      if (irq_err) n_e++;
      if (tc_pulse) n_tc++;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [63:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [63:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic fresh();
    wr(2'd2, C_RST);
    n_a = 0; n_b = 0; n_e = 0; n_tc = 0; beats = 0; reads = 0; writes = 0;
  endtask

  task automatic push_out(input logic [31:0] base, input int len);
    for (int i = 0; i < len; i++) exp_out.push_back(mem_pat(base + 32'(i)));
  endtask

  task automatic push_in(input logic [31:0] base, input int len);
    for (int i = 0; i < len; i++) begin
      logic [7:0] d;
      d = 8'(i * 37) ^ 8'h3C;
      src_in.push_back(d);
      exp_wr.push_back({base + 32'(i), d});
    end
  endtask

  task automatic drain(input string tag);
    int t = 0;
    while ((exp_out.size() != 0 || exp_wr.size() != 0) && t < 3000) begin
      @(negedge clk); t++;
    end
    check({tag, " buffer drained"}, 64'(t < 3000), 64'd1);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] r, d0;
    int b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // reset state
    rd(2'd2, r); check("R10 ctl after reset", r, 64'd0);
    rd(2'd3, r); check("R11 diag after reset", r, 64'd0);
    check("R9 outputs quiet after reset",
          {60'd0, mem_req, st_out_valid, st_in_ready, irq_a}, 64'd0);

    // T1: single memory-to-device slot with end flag
    fresh();
    push_out(32'h100, 5);
    wr(2'd0, slot_word(32'h100, 12'd5, 1'b1));
    rd(2'd0, r); check("R1 slot A readback", r, slot_word(32'h100, 12'd5, 1'b1));
    wr(2'd2, C_EN | C_VA);
    drain("R2");
    check("R2 memory reads", 64'(reads), 64'd5);
    check("R5 irq_a count", 64'(n_a), 64'd1);
    check("R6 tc with end flag", 64'(n_tc), 64'd1);
    rd(2'd2, r); check("R4 slot A valid cleared", r, C_EN);
    rd(2'd3, r); check("R11 diag idle on slot B", r, 64'd1);

    // T2: alternating A then B, unaligned base in memory-to-device
    fresh();
    push_out(32'h203, 7); push_out(32'h400, 3);
    wr(2'd0, slot_word(32'h203, 12'd7, 1'b0));
    wr(2'd1, slot_word(32'h400, 12'd3, 1'b1));
    rd(2'd1, r); check("R1 slot B readback", r, slot_word(32'h400, 12'd3, 1'b1));
    wr(2'd2, C_EN | C_VA | C_VB);
    drain("R4");
    check("R8 unaligned accepted for output", 64'(n_e), 64'd0);
    check("R5 one irq each", 64'({n_a[7:0], n_b[7:0]}), 64'h0101);
    check("R6 tc only for B", 64'(n_tc), 64'd1);
    rd(2'd3, r); check("R4 back on slot A", r, 64'd0);

    // T3: device-to-memory
    fresh();
    push_in(32'h840, 4);
    wr(2'd0, slot_word(32'h840, 12'd4, 1'b1));
    wr(2'd2, C_EN | C_DIR | C_VA);
    drain("R3");
    check("R3 write count", 64'(writes), 64'd4);
    check("R6 tc for device-to-memory", 64'(n_tc), 64'd1);

    // T4: page crossing refused
    fresh();
    wr(2'd0, slot_word(32'h0FF0, 12'h011, 1'b1));
    wr(2'd2, C_EN | C_VA);
    repeat (8) @(negedge clk);
    check("R7 error pulse", 64'(n_e), 64'd1);
    check("R7 no completion or traffic", 64'(n_a + n_tc + beats + reads), 64'd0);
    rd(2'd2, r); check("R7 valid cleared", r, C_EN);
    rd(2'd3, r); check("R7 moved to slot B", r, 64'd1);

    // T5: ending exactly on the page boundary
    fresh();
    push_out(32'h0FF0, 16);
    wr(2'd0, slot_word(32'h0FF0, 12'h010, 1'b0));
    wr(2'd2, C_EN | C_VA);
    drain("R7 boundary");
    check("R7 boundary completes", 64'({n_a[7:0], n_e[7:0]}), 64'h0100);

    // T6: misaligned device-to-memory refused
    fresh();
    wr(2'd0, slot_word(32'h841, 12'd4, 1'b0));
    wr(2'd2, C_EN | C_DIR | C_VA);
    repeat (8) @(negedge clk);
    check("R8 misaligned refused", 64'({n_e[7:0], n_a[7:0]}), 64'h0100);
    check("R8 no writes", 64'(writes + beats), 64'd0);

    // T7: zero length
    fresh();
    wr(2'd0, slot_word(32'h10, 12'd0, 1'b1));
    wr(2'd2, C_EN | C_VA);
    repeat (6) @(negedge clk);
    check("R12 completion irq", 64'(n_a), 64'd1);
    check("R12 tc", 64'(n_tc), 64'd1);
    check("R12 no traffic", 64'(beats + reads), 64'd0);

    // T8: set-only valid flags, idle wait, resume on set
    fresh();
    wr(2'd2, C_VB);
    wr(2'd2, 64'd0);
    rd(2'd2, r); check("R13 writing zero keeps B valid", r, C_VB);
    push_out(32'h500, 2); push_out(32'h600, 2);
    wr(2'd0, slot_word(32'h500, 12'd2, 1'b0));
    wr(2'd1, slot_word(32'h600, 12'd2, 1'b0));
    wr(2'd2, C_EN | C_VA);
    drain("R4 pair");
    repeat (10) @(negedge clk);
    check("R4 both ran once", 64'({n_a[7:0], n_b[7:0]}), 64'h0101);
    rd(2'd3, r); check("R4 idle waiting on A", r, 64'd0);
    push_out(32'h500, 2);
    wr(2'd2, C_EN | C_VA);
    drain("R4 resume");
    check("R4 A ran again", 64'(n_a), 64'd2);

    // T9: freeze and resume
    fresh();
    push_out(32'h000, 20);
    wr(2'd0, slot_word(32'h000, 12'd20, 1'b1));
    wr(2'd2, C_EN | C_VA);
    while (beats < 5) @(negedge clk);
    wr(2'd2, 64'd0);
    b0 = beats;
    rd(2'd3, d0);
    repeat (20) @(negedge clk);
    check("R9 no beats while frozen", 64'(beats), 64'(b0));
    rd(2'd3, r); check("R9 diag holds while frozen", r, d0);
    check("R11 remaining count", 64'(d0[13:2]), 64'(20 - b0));
    check("R11 active and slot", 64'(d0[1:0]), 64'd2);
    wr(2'd2, C_EN);
    drain("R9 resume");
    check("R9 all bytes after resume", 64'({n_a[7:0], n_tc[7:0]}), 64'h0101);

    // T10: soft reset mid-transfer
    fresh();
    push_out(32'h300, 30);
    wr(2'd0, slot_word(32'h300, 12'd30, 1'b1));
    wr(2'd1, slot_word(32'h700, 12'd30, 1'b1));
    wr(2'd2, C_EN | C_VA | C_VB);
    while (beats < 3) @(negedge clk);
    wr(2'd2, C_EN | C_RST);
    exp_out.delete();
    rd(2'd3, r); check("R10 diag cleared", r, 64'd0);
    rd(2'd2, r); check("R10 valid flags cleared", r, C_EN);
    b0 = beats;
    repeat (12) @(negedge clk);
    check("R10 no traffic after reset", 64'(beats), 64'(b0));
    check("R10 no completion", 64'(n_a + n_b), 64'd0);

    done_flag = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule